// File: doc/BRIEF.md
# Event Readout Controller with Buffer Validation

This block is the control sequencer of one readout crate. It walks through eight phases: idle after reset, available for a run, pipeline initialisation, ready for a trigger, pipeline copy, waiting for a free event buffer, waiting for the trigger to drop, and waiting for the processor. While it does this it keeps a rotating index over ten event buffers and drives a BUSY output that tells the upstream trigger source whether another trigger can be taken. The copy addressing is outside this block. The block only sees the copy-done pulse.

A readout processor sees results through a 14-bit interrupt status register and a matching enable mask. Hardware sets the status bits. The processor can only clear them. Clearing a buffer's valid bit hands that buffer back to the controller. The active-low interrupt line is low whenever an enabled status bit is set. Two processor-owned holds, freeze and end-of-run, can stop the controller after an event has been validated.

Top module: `rdo_ctrl`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) and the synchronous reset command `soft_rst_i` both put the controller into the idle phase (`state_o` = 8'h01). They also clear the buffer index, the interrupt status and the mask.
- R2: From idle, `run_req_i` high moves to available (`state_o` = 8'h02). In available, `run_req_i` low returns to idle, and this takes priority over initialise.
- R3: `init_i` in available or ready moves to initialise (`state_o` = 8'h04). An initialise from available also clears the buffer index. In synchronised mode (`solo_i` low) initialise waits for a `sync_i` pulse. In stand-alone mode it moves to ready (`state_o` = 8'h08) at the next edge.
- R4: In ready, `trig_i` high moves to copy (`state_o` = 8'h10). `copy_done_i` in copy moves to wait-buffer (8'h20). Wait-buffer moves to wait-valid (8'h40) once the next buffer is free.
- R5: The next buffer is (index+1) mod 10. Wait-buffer holds while that buffer's valid bit (status bit 1+k for buffer k) is set.
- R6: In wait-valid, a falling edge of `trig_i` validates the event, either stored since the trigger was accepted or seen at this edge. Validation sets status bit 1+index and advances the index, which wraps from 9 to 0.
- R7: `abort_i`, while `trig_i` is high and has not fallen since the trigger was accepted, returns copy, wait-buffer or wait-valid to ready. It sets no valid bit and leaves the index unchanged. Once the trigger has fallen, abort has no effect.
- R8: If `freeze_i` or `eor_i` is high at validation, the controller enters wait-processor (8'h80). It leaves only when both are low. It goes to available if end-of-run was high at validation, and to ready otherwise.
- R9: `busy_o` is high in idle, initialise, copy, wait-buffer and wait-processor, and low in the other phases. It is always high when `solo_i` is high.
- R10: Status bit 0 follows BUSY, bits 1-10 are buffer valid flags, bit 11 is trigger accepted, bit 12 is copy done and bit 13 is initialise entered. A write clears each bit written 0 and keeps each bit written 1. A clear beats a set in the same cycle. For example, writing 14'h3EFE clears only bits 0 and 8.
- R11: `irq_no` is low exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous reset command |
| run_req_i | input | 1 | Control request (1) / release (0) |
| solo_i | input | 1 | Stand-alone test mode |
| init_i | input | 1 | Initialise command pulse |
| trig_i | input | 1 | Trigger level |
| abort_i | input | 1 | Abort command pulse |
| sync_i | input | 1 | Bunch-crossing-zero pulse |
| copy_done_i | input | 1 | Pipeline copy complete pulse |
| freeze_i | input | 1 | Pipeline freeze hold |
| eor_i | input | 1 | End-of-run hold |
| irq_wr_i | input | 1 | Status clear write strobe |
| irq_wdata_i | input | 14 | Status write data (0 = clear) |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 14 | Mask write data |
| busy_o | output | 1 | BUSY to trigger source |
| state_o | output | 8 | One-hot phase vector |
| buf_cnt_o | output | 4 | Current buffer index |
| irq_status_o | output | 14 | Interrupt status read-back |
| irq_no | output | 1 | Interrupt line, active low |

## Verification
On every cycle the assertions check these properties: the phase vector stays one-hot, the index stays below ten and only steps by one or to zero, copy is entered only from ready, BUSY is high while idle or in stand-alone mode, and any bit written 0 reads as 0 on the next cycle. The bench's scenarios show the rest: the wait-buffer hold at wrap-around, the effect of abort before and after the trigger falls, the exit destinations from wait-processor, the index clear on the first initialise, and the collision between a clear and a set.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_AVAIL = 3'd1,
    ST_INIT  = 3'd2,
    ST_READY = 3'd3,
    ST_COPY  = 3'd4,
    ST_WBUF  = 3'd5,
    ST_WVAL  = 3'd6,
    ST_WPROC = 3'd7
  } rdo_state_e;

  localparam int unsigned NUM_ST = 8;
endpackage

// File: rtl/rdo_trig_edge.sv
module rdo_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic trig_i,
  output logic fell_o,
  output logic fall_now_o
);
  logic trig_q, fell_q;

  assign fall_now_o = trig_q & ~trig_i;
  assign fell_o     = fell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      fell_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (clr_i || arm_i)   fell_q <= 1'b0;
      else if (fall_now_o)  fell_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rdo_seq.sv
module rdo_seq
  import rdo_pkg::*;
#(
  parameter int unsigned NUM_BUF = 10,
  parameter int unsigned CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               run_req_i,
  input  logic               solo_i,
  input  logic               init_i,
  input  logic               trig_i,
  input  logic               abort_i,
  input  logic               sync_i,
  input  logic               copy_done_i,
  input  logic               freeze_i,
  input  logic               eor_i,
  input  logic               fell_i,
  input  logic               fall_now_i,
  input  logic [NUM_BUF-1:0] valid_i,
  output rdo_state_e         state_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               busy_o,
  output logic               ev_trig_o,
  output logic               ev_copy_o,
  output logic               ev_init_o,
  output logic               ev_val_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BUF - 1);

  rdo_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, nxt;
  logic             eorh_q, eorh_d;
  logic             abort_ok;

  assign nxt      = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  assign abort_ok = abort_i & trig_i & ~fell_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    eorh_d    = eorh_q;
    ev_trig_o = 1'b0;
    ev_copy_o = 1'b0;
    ev_init_o = 1'b0;
    ev_val_o  = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (run_req_i) st_d = ST_AVAIL;
      ST_AVAIL: begin
        if (!run_req_i) st_d = ST_IDLE;
        else if (init_i) begin
          st_d      = ST_INIT;
          cnt_d     = '0;
          ev_init_o = 1'b1;
        end
      end
      ST_INIT:  if (solo_i || sync_i) st_d = ST_READY;
      ST_READY: begin
        if (init_i) begin
          st_d      = ST_INIT;
          ev_init_o = 1'b1;
        end else if (trig_i) begin
          st_d      = ST_COPY;
          ev_trig_o = 1'b1;
        end
      end
      ST_COPY: begin
        if (abort_ok) st_d = ST_READY;
        else if (copy_done_i) begin
          st_d      = ST_WBUF;
          ev_copy_o = 1'b1;
        end
      end
      ST_WBUF: begin
        if (abort_ok) st_d = ST_READY;
        else if (!valid_i[nxt]) st_d = ST_WVAL;
      end
      ST_WVAL: begin
        if (abort_ok) st_d = ST_READY;
        else if (fell_i || fall_now_i) begin
          ev_val_o = 1'b1;
          cnt_d    = nxt;
          if (freeze_i || eor_i) begin
            st_d   = ST_WPROC;
            eorh_d = eor_i;
          end else st_d = ST_READY;
        end
      end
      ST_WPROC: if (!freeze_i && !eor_i) st_d = eorh_q ? ST_AVAIL : ST_READY;
      default:  st_d = ST_IDLE;
    endcase
    if (soft_rst_i) begin
      st_d      = ST_IDLE;
      cnt_d     = '0;
      eorh_d    = 1'b0;
      ev_trig_o = 1'b0;
      ev_copy_o = 1'b0;
      ev_init_o = 1'b0;
      ev_val_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      eorh_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      eorh_q <= eorh_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE, ST_INIT, ST_COPY, ST_WBUF, ST_WPROC: busy_o = 1'b1;
      default:                                      busy_o = solo_i;
    endcase
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rdo_irq.sv
module rdo_irq #(
  parameter int unsigned IRQ_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic             mwr_i,
  input  logic [IRQ_W-1:0] mwdata_i,
  output logic [IRQ_W-1:0] stat_o,
  output logic             irq_no
);
  logic [IRQ_W-1:0] stat_q, mask_q, keep;

  assign keep = wr_i ? wdata_i : '1;  // clear beats set

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else if (soft_rst_i) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q | set_i) & keep;
      if (mwr_i) mask_q <= mwdata_i;
    end
  end

  assign stat_o = stat_q;
  assign irq_no = ~|(stat_q & mask_q);
endmodule

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
  import rdo_pkg::*;
#(
  parameter  int unsigned NUM_BUF = 10,
  localparam int unsigned CNT_W   = $clog2(NUM_BUF),
  localparam int unsigned IRQ_W   = NUM_BUF + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              run_req_i,
  input  logic              solo_i,
  input  logic              init_i,
  input  logic              trig_i,
  input  logic              abort_i,
  input  logic              sync_i,
  input  logic              copy_done_i,
  input  logic              freeze_i,
  input  logic              eor_i,
  input  logic              irq_wr_i,
  input  logic [IRQ_W-1:0]  irq_wdata_i,
  input  logic              mask_wr_i,
  input  logic [IRQ_W-1:0]  mask_wdata_i,
  output logic              busy_o,
  output logic [NUM_ST-1:0] state_o,
  output logic [CNT_W-1:0]  buf_cnt_o,
  output logic [IRQ_W-1:0]  irq_status_o,
  output logic              irq_no
);
  localparam int unsigned B_TRIG = NUM_BUF + 1;
  localparam int unsigned B_COPY = NUM_BUF + 2;
  localparam int unsigned B_INIT = NUM_BUF + 3;

  rdo_state_e       st;
  logic             fell, fall_now;
  logic             ev_trig, ev_copy, ev_init, ev_val;
  logic [IRQ_W-1:0] set_vec;

  rdo_trig_edge i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i),
    .arm_i     (ev_trig),
    .trig_i    (trig_i),
    .fell_o    (fell),
    .fall_now_o(fall_now)
  );

  rdo_seq #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .run_req_i  (run_req_i),
    .solo_i     (solo_i),
    .init_i     (init_i),
    .trig_i     (trig_i),
    .abort_i    (abort_i),
    .sync_i     (sync_i),
    .copy_done_i(copy_done_i),
    .freeze_i   (freeze_i),
    .eor_i      (eor_i),
    .fell_i     (fell),
    .fall_now_i (fall_now),
    .valid_i    (irq_status_o[NUM_BUF:1]),
    .state_o    (st),
    .cnt_o      (buf_cnt_o),
    .busy_o     (busy_o),
    .ev_trig_o  (ev_trig),
    .ev_copy_o  (ev_copy),
    .ev_init_o  (ev_init),
    .ev_val_o   (ev_val)
  );

  assign set_vec[0]      = busy_o;
  assign set_vec[B_TRIG] = ev_trig;
  assign set_vec[B_COPY] = ev_copy;
  assign set_vec[B_INIT] = ev_init;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_vset
    assign set_vec[1+g] = ev_val && (buf_cnt_o == CNT_W'(g));
  end

  for (genvar g = 0; g < NUM_ST; g++) begin : g_st
    assign state_o[g] = (st == rdo_state_e'(g));
  end

  rdo_irq #(.IRQ_W(IRQ_W)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .set_i     (set_vec),
    .wr_i      (irq_wr_i),
    .wdata_i   (irq_wdata_i),
    .mwr_i     (mask_wr_i),
    .mwdata_i  (mask_wdata_i),
    .stat_o    (irq_status_o),
    .irq_no    (irq_no)
  );
endmodule

// File: rtl/rdo_ctrl_chk.sv
module rdo_ctrl_chk #(
  parameter int unsigned NUM_BUF = 10,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned IRQ_W   = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             solo_i,
  input logic             irq_wr_i,
  input logic [IRQ_W-1:0] irq_wdata_i,
  input logic             busy_o,
  input logic [7:0]       state_o,
  input logic [CNT_W-1:0] buf_cnt_o,
  input logic [IRQ_W-1:0] irq_status_o
);
  assert_state_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_cnt_o < CNT_W'(NUM_BUF));

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_cnt_o != $past(buf_cnt_o)) |->
      (buf_cnt_o == '0 || buf_cnt_o == $past(buf_cnt_o) + 1'b1));

  assert_copy_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o[4]) |-> $past(state_o[3]));

  assert_busy_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o[0] || solo_i) |-> busy_o);

  assert_clear_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wr_i |=> ((irq_status_o & ~$past(irq_wdata_i)) == '0));
endmodule

bind rdo_ctrl rdo_ctrl_chk #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W), .IRQ_W(IRQ_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .solo_i      (solo_i),
  .irq_wr_i    (irq_wr_i),
  .irq_wdata_i (irq_wdata_i),
  .busy_o      (busy_o),
  .state_o     (state_o),
  .buf_cnt_o   (buf_cnt_o),
  .irq_status_o(irq_status_o)
);

// File: tb/test_rdo_ctrl.sv
module test_rdo_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 10;
  localparam int IW = 14;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic soft_rst = 0, run_req = 0, solo = 0, init = 0, trig = 0, abort_c = 0;
  logic sync = 0, copy_done = 0, freeze = 0, eor = 0;
  logic irq_wr = 0, mask_wr = 0;
  logic [IW-1:0] irq_wdata = '0, mask_wdata = '0;
  logic busy;
  logic [7:0] state;
  logic [3:0] cnt;
  logic [IW-1:0] irq_stat;
  logic irq_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdo_ctrl i_rdo_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst), .run_req_i(run_req),
    .solo_i(solo), .init_i(init), .trig_i(trig), .abort_i(abort_c), .sync_i(sync),
    .copy_done_i(copy_done), .freeze_i(freeze), .eor_i(eor),
    .irq_wr_i(irq_wr), .irq_wdata_i(irq_wdata), .mask_wr_i(mask_wr),
    .mask_wdata_i(mask_wdata), .busy_o(busy), .state_o(state), .buf_cnt_o(cnt),
    .irq_status_o(irq_stat), .irq_no(irq_n)
  );

  // behavioural reference: phase codes 0 idle,1 avail,2 init,3 ready,4 copy,5 wbuf,6 wval,7 wproc
  int m_st, m_cnt;
  logic [IW-1:0] m_irq, m_mask;
  bit m_trq, m_fell, m_eorh;

  function automatic bit m_busy();
    return solo || m_st inside {0, 2, 4, 5, 7};
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_irq = '0; m_mask = '0; m_trq = 0; m_fell = 0; m_eorh = 0;
    end else begin
      logic [IW-1:0] setv;
      int nst, ncnt;
      bit fall_now, abort_ok, arm;
      setv = '0; nst = m_st; ncnt = m_cnt; arm = 0;
      setv[0] = m_busy();
      fall_now = m_trq && !trig;
      abort_ok = abort_c && trig && !m_fell;
      if (soft_rst) begin
        nst = 0; ncnt = 0; m_eorh = 0;
      end else begin
        case (m_st)
          0: if (run_req) nst = 1;
          1: if (!run_req) nst = 0;
             else if (init) begin nst = 2; ncnt = 0; setv[13] = 1; end
          2: if (solo || sync) nst = 3;
          3: if (init) begin nst = 2; setv[13] = 1; end
             else if (trig) begin nst = 4; setv[11] = 1; arm = 1; end
          4: if (abort_ok) nst = 3;
             else if (copy_done) begin nst = 5; setv[12] = 1; end
          5: if (abort_ok) nst = 3;
             else if (!m_irq[1 + (m_cnt + 1) % NB]) nst = 6;
          6: if (abort_ok) nst = 3;
             else if (m_fell || fall_now) begin
               setv[1 + m_cnt] = 1;
               ncnt = (m_cnt + 1) % NB;
               if (freeze || eor) begin nst = 7; m_eorh = eor; end
               else nst = 3;
             end
          default: if (!freeze && !eor) nst = m_eorh ? 1 : 3;
        endcase
      end
      if (soft_rst) begin
        m_irq = '0; m_mask = '0;
      end else begin
        m_irq = (m_irq | setv) & (irq_wr ? irq_wdata : {IW{1'b1}});
        if (mask_wr) m_mask = mask_wdata;
      end
      if (soft_rst || arm) m_fell = 0;
      else if (fall_now) m_fell = 1;
      m_trq = trig;
      m_st = nst; m_cnt = ncnt;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // advance one edge, then compare all outputs against the model
  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (rst_ni) begin
        chk("R4 state", int'(state), 1 << m_st);
        chk("R9 busy", int'(busy), int'(m_busy()));
        chk("R6 count", int'(cnt), m_cnt);
        chk("R10 status", int'(irq_stat), int'(m_irq));
        chk("R11 line", int'(irq_n), int'(~|(m_irq & m_mask)));
      end
    end
  endtask

  task automatic ev();
    trig = 1; cyc();
    copy_done = 1; cyc(); copy_done = 0;
    cyc();
    trig = 0; cyc();
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc();
    chk("R1 idle after reset", int'(state), 8'h01);
    chk("R1 count after reset", int'(cnt), 0);
    chk("R1 line idle", int'(irq_n), 1);

    run_req = 1; cyc();
    chk("R2 available", int'(state), 8'h02);
    run_req = 0; cyc();
    chk("R2 release to idle", int'(state), 8'h01);
    run_req = 1; cyc();

    init = 1; cyc(); init = 0;
    chk("R3 initialise", int'(state), 8'h04);
    cyc(3);
    chk("R3 waits for sync", int'(state), 8'h04);
    sync = 1; cyc(); sync = 0;
    chk("R3 ready after sync", int'(state), 8'h08);

    trig = 1; cyc();
    chk("R4 copy on trigger", int'(state), 8'h10);
    chk("R9 busy in copy", int'(busy), 1);
    copy_done = 1; cyc(); copy_done = 0;
    chk("R4 wait buffer", int'(state), 8'h20);
    cyc();
    chk("R4 wait valid", int'(state), 8'h40);
    trig = 0; cyc(2);
    chk("R6 validated", int'(irq_stat[1]), 1);
    chk("R6 count one", int'(cnt), 1);

    for (int k = 0; k < 8; k++) ev();
    chk("R6 count nine", int'(cnt), 9);

    // next buffer 0 still valid: hold in wait-buffer
    trig = 1; cyc();
    copy_done = 1; cyc(); copy_done = 0;
    cyc(3);
    chk("R5 hold while next busy", int'(state), 8'h20);
    trig = 0; cyc();
    irq_wr = 1; irq_wdata = ~14'h0002; cyc(); irq_wr = 0;
    chk("R10 buffer 0 cleared", int'(irq_stat[1]), 0);
    cyc(2);
    chk("R6 wrap to zero", int'(cnt), 0);
    chk("R6 buffer 9 valid", int'(irq_stat[10]), 1);

    irq_wr = 1; irq_wdata = '0; cyc(); irq_wr = 0;

    // abort while trigger high
    trig = 1; cyc();
    abort_c = 1; cyc(); abort_c = 0;
    chk("R7 abort to ready", int'(state), 8'h08);
    chk("R7 count kept", int'(cnt), 0);
    trig = 0; cyc();
    chk("R7 no valid bit", int'(irq_stat[1]), 0);

    // abort after fall ignored
    trig = 1; cyc();
    trig = 0; cyc();
    abort_c = 1; cyc(); abort_c = 0;
    chk("R7 abort ignored after fall", int'(state), 8'h10);
    copy_done = 1; cyc(); copy_done = 0;
    cyc(2);
    chk("R7 late abort still validates", int'(cnt), 1);

    freeze = 1; ev();
    chk("R8 freeze hold", int'(state), 8'h80);
    freeze = 0; cyc();
    chk("R8 freeze exit ready", int'(state), 8'h08);

    eor = 1; ev();
    chk("R8 eor hold", int'(state), 8'h80);
    eor = 0; cyc();
    chk("R8 eor exit available", int'(state), 8'h02);
    init = 1; cyc(); init = 0;
    chk("R3 first init clears count", int'(cnt), 0);
    sync = 1; cyc(); sync = 0;
    irq_wr = 1; irq_wdata = '0; cyc(); irq_wr = 0;

    // clear and set collide on trigger bit
    irq_wr = 1; irq_wdata = ~14'h0800; trig = 1; cyc(); irq_wr = 0;
    chk("R10 clear wins", int'(irq_stat[11]), 0);
    copy_done = 1; cyc(); copy_done = 0;
    cyc(); trig = 0; cyc(2);

    ev();
    irq_wr = 1; irq_wdata = 14'h3EFE; cyc(); irq_wr = 0;
    chk("R10 bit8 cleared", int'(irq_stat[8]), 0);
    chk("R10 bit11 kept", int'(irq_stat[11]), 1);
    mask_wr = 1; mask_wdata = 14'h0800; cyc(); mask_wr = 0;
    chk("R11 line asserted", int'(irq_n), 0);
    mask_wr = 1; mask_wdata = 14'h0001; cyc(); mask_wr = 0;
    cyc();
    chk("R11 line released", int'(irq_n), 1);

    soft_rst = 1; cyc(); soft_rst = 0;
    chk("R1 soft reset idle", int'(state), 8'h01);
    chk("R1 soft reset status", int'(irq_stat), 0);

    solo = 1; cyc();
    chk("R9 solo busy in available", int'(busy), 1);
    init = 1; cyc(); init = 0;
    cyc();
    chk("R3 solo straight to ready", int'(state), 8'h08);
    chk("R9 solo busy in ready", int'(busy), 1);
    ev();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule